// File: doc/BRIEF.md
# Four-Rail Power Sequencer

This block powers a group of downstream devices up and down through four supply rails. A host uses a small byte-wide register port. It writes bit 0 of a control register to ask for power, or clears that bit to ask for the rails to be removed. On a request for power, the block drives the rail enables one at a time, starting with rail 0. Each later rail waits until the power-good input of the rail below it has stayed high for a programmable number of cycles. On a request to remove power, the rails are dropped from the highest rail down. The block then waits for every power-good to fall, with a bounded timeout, before it accepts another request.

A status byte shows the four synchronised power-good inputs and an alarm flag. A fully powered system reads exactly 0x0F there. A rail that does not come up in time, or a power-good that drops while the rail is driven, sets the alarm, marks the offending rail in a fail byte and shuts everything down. A version byte lets software confirm the register layout.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: The registers sit at fixed byte addresses: layout id at 0x2000 (reads 0x03), control at 0x2006, status at 0x200A and fail byte at 0x200B. Any other address reads 0x00. After reset the control, status and fail bytes read 0x00.
- R2: Writing a byte with bit 0 set to the control address while the block is off starts power-up. Control then reads 0x01 from the next cycle, and rail 0 is the first enable to rise.
- R3: Rail k (k = 1..3) is enabled only after the power-good of rail k-1 has been seen high for SETTLE_CYC consecutive cycles.
- R4: Status bits 3..0 show the power-good inputs after a two-flop synchroniser, so an input change appears two clock edges later. Bit 4 is the alarm, and a fully powered block reads exactly 0x0F.
- R5: Writing a byte with bit 0 clear while powering up or powered drops the rail enables one per cycle from rail 3 down to rail 0. The block goes idle once all power-goods read low.
- R6: A power-good that falls while all rails are on sets the alarm on the third clock edge after the input change. The rail's bit (bit i for rail i) is set in the fail byte, and all rails are then removed.
- R7: A rail whose power-good has not settled within UP_TMO_CYC cycles of its enable sets the alarm, sets its fail bit and causes shutdown.
- R8: The alarm and the fail byte are held until an accepted enable write clears them. A write of 0x00 while the block is off leaves them unchanged.
- R9: An enable write that arrives during power-down or discharge is ignored. The block ends off with control reading 0x00.
- R10: If a power-good stays high after the rails are removed, the block returns to off after DRAIN_TMO_CYC cycles, and a later enable write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pgood_in | input | 4 | Asynchronous power-good per rail |
| rail_en | output | 4 | Enable per rail |

## Verification
A write takes effect at the clock edge that follows the strobe, so the control byte is read back one cycle later. A change on a power-good input appears in the status byte after exactly two edges. A fault shows up as the alarm bit on the third edge. The bench sets up the address and changes the inputs on falling edges, then samples read data just after the falling edge that follows the edge where the result is due. It checks the fault path at both the second edge (good bit clear, no alarm yet) and the third edge (alarm set). Sequencing order, settle gaps and timeouts depend on a behavioural rail model with a fixed delay, so they are checked by recorded edge times and by polling with bounded limits, not by exact cycle counts.

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer #(
  parameter int              ADDR_W        = 16,
  parameter logic [15:0]     A_LAYOUT      = 16'h2000,
  parameter logic [15:0]     A_CTRL        = 16'h2006,
  parameter logic [15:0]     A_STATUS      = 16'h200A,
  parameter logic [15:0]     A_FAIL        = 16'h200B,
  parameter logic [7:0]      LAYOUT_ID     = 8'h03,
  parameter int              SETTLE_CYC    = 16,
  parameter int              UP_TMO_CYC    = 1000,
  parameter int              DRAIN_TMO_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [3:0]        pgood_in,
  output logic [3:0]        rail_en
);
  localparam int NR   = 4;
  localparam int M1   = (UP_TMO_CYC > DRAIN_TMO_CYC) ? UP_TMO_CYC : DRAIN_TMO_CYC;
  localparam int MAXC = (M1 > SETTLE_CYC) ? M1 : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_OFF, S_UP, S_ON, S_DOWN, S_DRAIN} st_t;

  st_t            st;
  logic [NR-1:0]  pg_m, pg, en_q, fail_q;
  logic           alarm_q;
  logic [1:0]     stg;
  logic [CW-1:0]  settle, tmo;

  wire ctl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  wire req_on  = ctl_wr &&  bus_wdata[0];
  wire req_off = ctl_wr && !bus_wdata[0];

  wire [NR-1:0] cur_bit   = NR'(1) << stg;
  wire [NR-1:0] lower_bad = en_q & ~cur_bit & ~pg;
  wire          settled   = pg[stg] && (settle == CW'(SETTLE_CYC - 1));
  wire [NR-1:0] en_shrunk = en_q & (en_q >> 1);
  wire          powered   = (st == S_UP) || (st == S_ON);

  assign rail_en = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_m <= '0;
      pg   <= '0;
    end else begin
      pg_m <= pgood_in;
      pg   <= pg_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_OFF;
      en_q    <= '0;
      fail_q  <= '0;
      alarm_q <= 1'b0;
      stg     <= '0;
      settle  <= '0;
      tmo     <= '0;
    end else begin
      case (st)
        S_OFF: begin
          if (req_on) begin
            alarm_q <= 1'b0;
            fail_q  <= '0;
            en_q    <= NR'(1);
            stg     <= '0;
            settle  <= '0;
            tmo     <= '0;
            st      <= S_UP;
          end
        end
        S_UP: begin
          if (|lower_bad) begin
            alarm_q <= 1'b1;
            fail_q  <= fail_q | lower_bad;
            st      <= S_DOWN;
          end else if (req_off) begin
            st <= S_DOWN;
          end else if (settled) begin
            settle <= '0;
            tmo    <= '0;
            if (stg == 2'(NR - 1)) begin
              st <= S_ON;
            end else begin
              stg  <= stg + 2'd1;
              en_q <= en_q | (cur_bit << 1);
            end
          end else if (tmo == CW'(UP_TMO_CYC - 1)) begin
            alarm_q <= 1'b1;
            fail_q  <= fail_q | cur_bit;
            st      <= S_DOWN;
          end else begin
            settle <= pg[stg] ? settle + CW'(1) : '0;
            tmo    <= tmo + CW'(1);
          end
        end
        S_ON: begin
          if (pg != '1) begin
            alarm_q <= 1'b1;
            fail_q  <= fail_q | ~pg;
            st      <= S_DOWN;
          end else if (req_off) begin
            st <= S_DOWN;
          end
        end
        S_DOWN: begin
          en_q <= en_shrunk;
          if (en_shrunk == '0) begin
            tmo <= '0;
            st  <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (pg == '0 || tmo == CW'(DRAIN_TMO_CYC - 1)) st <= S_OFF;
          else tmo <= tmo + CW'(1);
        end
        default: st <= S_OFF;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if      (bus_addr == ADDR_W'(A_LAYOUT)) bus_rdata = LAYOUT_ID;
    else if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = {7'd0, powered};
    else if (bus_addr == ADDR_W'(A_STATUS)) bus_rdata = {3'd0, alarm_q, pg};
    else if (bus_addr == ADDR_W'(A_FAIL))   bus_rdata = {4'd0, fail_q};
  end

  a_r1_off_no_rails: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF) |-> (rail_en == '0));

  for (genvar k = 1; k < NR; k++) begin : g_up_chk
    a_r3_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rail_en[k]) |-> $past(pg[k-1]));
  end

  for (genvar k = 0; k < NR - 1; k++) begin : g_dn_chk
    a_r5_reverse_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rail_en[k]) |-> !rail_en[k+1]);
  end

  a_r6_fault_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ON && pg != '1) |=> (st == S_DOWN && alarm_q));

  a_r8_alarm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !(st == S_OFF && req_on)) |=> alarm_q);

  a_r9_ignore_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DOWN || st == S_DRAIN) && req_on) |=> (st != S_UP));

  a_r10_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && pg == '0) |=> (st == S_OFF));
endmodule

// File: tb/pwr_rail_sequencer_tb.sv
module pwr_rail_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int UP_TMO     = 40;
  localparam int DRAIN_TMO  = 30;
  localparam int RAIL_DLY   = 3;
  localparam logic [15:0] A_LAY = 16'h2000, A_CTL = 16'h2006, A_ST = 16'h200A, A_FL = 16'h200B;

  localparam int NV = 5;
  localparam logic [23:0] RST_VEC [NV] = '{
    {16'h2000, 8'h03}, {16'h2006, 8'h00}, {16'h200A, 8'h00},
    {16'h200B, 8'h00}, {16'h2001, 8'h00}};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [15:0] bus_addr = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic [3:0]  pgood_in, rail_en;
  logic [3:0]  kill = 0, stuck = 0;
  int          up_cnt [4];
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_rail_sequencer #(.SETTLE_CYC(SETTLE), .UP_TMO_CYC(UP_TMO), .DRAIN_TMO_CYC(DRAIN_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pgood_in(pgood_in), .rail_en(rail_en));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++)
      up_cnt[i] <= !rail_en[i] ? 0 : (up_cnt[i] < RAIL_DLY ? up_cnt[i] + 1 : up_cnt[i]);
  end
  always_comb
    for (int i = 0; i < 4; i++)
      pgood_in[i] = ((up_cnt[i] >= RAIL_DLY) && !kill[i]) || stuck[i];

  int hi_cnt [4], rise_t [4], fall_t [4], rise_hi [4];
  logic [3:0] prev_en = 0;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (rail_en[i] && !prev_en[i]) begin
        rise_t[i]  = cyc;
        rise_hi[i] = (i > 0) ? hi_cnt[i-1] : 0;
      end
      if (!rail_en[i] && prev_en[i]) fall_t[i] = cyc;
    end
    for (int i = 0; i < 4; i++) hi_cnt[i] = pgood_in[i] ? hi_cnt[i] + 1 : 0;
    prev_en = rail_en;
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wait_st(logic [7:0] exp, int lim, output logic [7:0] v);
    for (int n = 0; n < lim; n++) begin
      @(negedge clk); rd(A_ST, v);
      if (v == exp) break;
    end
  endtask

  task automatic power_up();
    logic [7:0] v;
    wr(A_CTL, 8'h01);
    wait_st(8'h0F, 300, v);
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_tb();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      rd(RST_VEC[i][23:8], v);
      chk("R1 reset/map", v, RST_VEC[i][7:0]);
    end

    // R2 / R3 / R4 power-up
    wr(A_CTL, 8'h01);
    rd(A_CTL, v); chk("R2 ctrl after enable", v, 8'h01);
    wait_st(8'h0F, 300, v);
    chk("R4 fully powered status", v, 8'h0F);
    chk("R2 rail0 first", int'(rise_t[0] < rise_t[1]), 1);
    for (int k = 1; k < 4; k++) begin
      chk("R3 rise order", int'(rise_t[k-1] < rise_t[k]), 1);
      chk("R3 settle before next rail", int'(rise_hi[k] >= SETTLE), 1);
    end

    // R5 power-down in reverse order
    wr(A_CTL, 8'h00);
    wait_st(8'h00, 200, v);
    chk("R5 idle status", v, 8'h00);
    chk("R5 rails off", rail_en, 4'h0);
    for (int k = 0; k < 3; k++)
      chk("R5 reverse fall", int'(fall_t[k+1] < fall_t[k]), 1);
    rd(A_CTL, v); chk("R5 ctrl off", v, 8'h00);

    // R6 fault while on, exact timing
    power_up();
    @(negedge clk); bus_addr = A_ST; kill[2] = 1;
    @(negedge clk); @(negedge clk);
    rd(A_ST, v); chk("R4 sync latency two edges", v, 8'h0B);
    @(negedge clk);
    rd(A_ST, v); chk("R6 alarm on third edge", v, 8'h1B);
    wait_st(8'h10, 200, v);
    chk("R6 alarm with rails gone", v, 8'h10);
    rd(A_FL, v); chk("R6 fail byte", v, 8'h04);
    chk("R6 rails off", rail_en, 4'h0);

    // R8 write 0 keeps latch; enable clears
    wr(A_CTL, 8'h00);
    rd(A_ST, v); chk("R8 alarm kept", v, 8'h10);
    rd(A_FL, v); chk("R8 fail kept", v, 8'h04);
    kill = 0;
    wr(A_CTL, 8'h01);
    rd(A_ST, v); chk("R8 alarm cleared", int'(v[4]), 0);
    rd(A_FL, v); chk("R8 fail cleared", v, 8'h00);
    wait_st(8'h0F, 300, v);
    chk("R8 repowered", v, 8'h0F);

    // R9 enable during power-down ignored
    wr(A_CTL, 8'h00);
    wr(A_CTL, 8'h01);
    repeat (60) @(negedge clk);
    rd(A_CTL, v); chk("R9 enable ignored ctrl", v, 8'h00);
    chk("R9 enable ignored rails", rail_en, 4'h0);

    // R7 rail 1 never good
    kill[1] = 1;
    wr(A_CTL, 8'h01);
    wait_st(8'h10, 300, v);
    chk("R7 timeout alarm", v, 8'h10);
    rd(A_FL, v); chk("R7 fail byte", v, 8'h02);
    kill = 0;

    // R10 stuck power-good during discharge
    power_up();
    stuck[3] = 1;
    wr(A_CTL, 8'h00);
    repeat (DRAIN_TMO + 20) @(negedge clk);
    rd(A_ST, v); chk("R10 stuck good no alarm", v, 8'h08);
    wr(A_CTL, 8'h01);
    rd(A_CTL, v); chk("R10 enable accepted after drain timeout", v, 8'h01);
    stuck = 0;
    wait_st(8'h0F, 300, v);
    chk("R10 repowered", v, 8'h0F);
    wr(A_CTL, 8'h00);
    wait_st(8'h00, 200, v);
    chk("R5 final off", v, 8'h00);

    finish_tb();
  end
endmodule